// File: doc/BRIEF.md
# Diagonal Quick-Test Sequencer

This block screens a memory die for massive failures before any full pattern test is spent on it. The memory is handled as two halves. In each half the sequencer walks a diagonal: row and column start at zero and move forward together, one cell per step. At every cell it writes one bit, reads the cell back and compares. Each mismatch on the path is counted against the half it lies in, because every such failure would need a spare row or column of its own.

Each half has its own spare budget, given on an input. When a half's count rises above that budget, the die cannot be repaired. The sequencer stops at once and reports the failure along with a request for a probe contact check. If neither half exceeds its budget, the walk covers both halves and ends with a pass. The per-half error counts are visible throughout the walk and stay valid after it ends.

The memory port is a plain synchronous single-port interface. Read data appears in the cycle after the address is presented with write enable low.

Top module: `qt_seq`

## Requirements
- R1: During and after reset the sequencer is idle: busy, done, passed, unrepairable, contactReq and memWe are low, and both error counts are zero.
- R2: A start pulse in the idle or done state clears both counts and all result flags. Busy is then high from the next cycle until the walk ends, and done is a level that holds until the next accepted start.
- R3: Each step takes three cycles. The first is a write cycle (memWe high). The second is a read cycle at the same address with memWe low. The compare uses memRdata in the third cycle. memAddr is laid out as {half (MSB), row (RB bits), column (CB low bits)}, where RB = clog2(ROWS_PER_HALF) and CB = clog2(COLS).
- R4: The bit written at each step equals bit 0 of the row index, so successive steps alternate 0, 1, 0, 1.
- R5: Half 0 is walked first and then half 1. Each half starts at row 0, column 0 and takes ROWS_PER_HALF steps. Row and column each increase by one per step, and the column wraps to 0 after COLS-1.
- R6: A read-back mismatch adds one to the count of the half being walked and leaves the other half's count alone. Cells off the diagonal are never written or read and so cannot affect the counts.
- R7: A half whose count equals its budget is still acceptable. When the walk finishes with neither count above its budget, done and passed go high.
- R8: The compare that first takes a count above its budget ends the walk. Done, unrepairable and contactReq are high from the next cycle, that count holds budget+1, and no further write is issued.
- R9: A start pulse while busy is ignored. The walk continues and the counts are not cleared.
- R10: After the walk ends, the error counts and result flags hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a walk |
| budgetHalf0 | input | CW | Spare budget of half 0 |
| budgetHalf1 | input | CW | Spare budget of half 1 |
| memAddr | output | AW | Memory address {half, row, column} |
| memWdata | output | 1 | Bit written in a write cycle |
| memWe | output | 1 | Write enable |
| memRdata | input | 1 | Read data, valid one cycle after a read address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk ended (level) |
| passed | output | 1 | Walk ended with both halves within budget |
| unrepairable | output | 1 | Walk ended because a half exceeded its budget |
| contactReq | output | 1 | Request for a probe contact check after a failed screen |
| errCount0 | output | CW | Diagonal failures found in half 0 |
| errCount1 | output | CW | Diagonal failures found in half 1 |

## Verification
The bench uses a column count that is not a power of two, so the column wraps in the middle of each half; a design that let the column overflow would address cells off the path. Faults of both polarities are placed on the diagonal, along with one next to it, so a design that wrote a constant bit, or counted an off-diagonal cell, would show wrong counts. The budgets are set at, just below and far below the real failure count. A strict/non-strict slip in the budget compare therefore flips the pass result, and a design that did not stop early would show too many busy cycles and extra writes. A start pulse is also sent mid-walk and after completion, to catch a design that restarts while busy or that loses its counts when done.

// File: rtl/qt_pkg.sv
package qt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // zero position and counts
    logic sample;    // compare cycle: count a mismatch
    logic stepNext;  // advance along the diagonal
  } seqStrobe_t;

endpackage

// File: rtl/qt_ctrl.sv
module qt_ctrl
  import qt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       overBudget,
  input  logic       lastStep,
  input  logic       inHalf1,
  output seqStrobe_t strobe,
  output logic       memWe,
  output logic       busy,
  output logic       done,
  output logic       unrepairable
);

  seqState_t state, nextState;
  logic      failFlag;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.clear = 1'b1;
          nextState    = ST_WRITE;
        end
      end
      ST_WRITE: nextState = ST_READ;
      ST_READ:  nextState = ST_CHECK;
      ST_CHECK: begin
        strobe.sample = 1'b1;
        if (overBudget) begin
          nextState = ST_DONE;
        end else if (lastStep && inHalf1) begin
          nextState = ST_DONE;
        end else begin
          strobe.stepNext = 1'b1;
          nextState       = ST_WRITE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      failFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.clear) begin
        failFlag <= 1'b0;
      end else if (state == ST_CHECK && overBudget) begin
        failFlag <= 1'b1;
      end
    end
  end

  assign memWe        = (state == ST_WRITE);
  assign busy         = (state == ST_WRITE) || (state == ST_READ) || (state == ST_CHECK);
  assign done         = (state == ST_DONE);
  assign unrepairable = done && failFlag;

endmodule

// File: rtl/qt_datapath.sv
module qt_datapath
  import qt_pkg::*;
#(
  parameter int ROWS_PER_HALF = 128,
  parameter int COLS          = 256,
  localparam int RB = $clog2(ROWS_PER_HALF),
  localparam int CB = $clog2(COLS),
  localparam int CW = $clog2(ROWS_PER_HALF + 1),
  localparam int AW = 1 + RB + CB
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic          memRdata,
  input  logic [CW-1:0] budgetHalf0,
  input  logic [CW-1:0] budgetHalf1,
  output logic [AW-1:0] memAddr,
  output logic          memWdata,
  output logic [CW-1:0] errCount0,
  output logic [CW-1:0] errCount1,
  output logic          overBudget,
  output logic          lastStep,
  output logic          inHalf1
);

  logic          halfSel;
  logic [RB-1:0] rowIdx;
  logic [CB-1:0] colIdx;
  logic [CW-1:0] cntQ [2];
  logic [CW-1:0] curCount;
  logic [CW-1:0] curBudget;
  logic          mismatch;

  assign lastStep = (rowIdx == RB'(ROWS_PER_HALF - 1));
  assign inHalf1  = halfSel;
  assign memAddr  = {halfSel, rowIdx, colIdx};
  assign memWdata = rowIdx[0];
  assign mismatch = (memRdata != rowIdx[0]);

  // position along the diagonal
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      halfSel <= 1'b0;
      rowIdx  <= '0;
      colIdx  <= '0;
    end else if (strobe.stepNext) begin
      if (lastStep) begin
        halfSel <= 1'b1;
        rowIdx  <= '0;
        colIdx  <= '0;
      end else begin
        rowIdx <= rowIdx + 1'b1;
        colIdx <= (colIdx == CB'(COLS - 1)) ? '0 : colIdx + 1'b1;
      end
    end
  end

  // one failure counter per half
  for (genvar h = 0; h < 2; h++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clear) begin
        cntQ[h] <= '0;
      end else if (strobe.sample && mismatch && (halfSel == 1'(h))) begin
        cntQ[h] <= cntQ[h] + 1'b1;
      end
    end
  end

  assign curCount   = halfSel ? cntQ[1] : cntQ[0];
  assign curBudget  = halfSel ? budgetHalf1 : budgetHalf0;
  assign overBudget = ({1'b0, curCount} + (CW+1)'(mismatch)) > {1'b0, curBudget};
  assign errCount0  = cntQ[0];
  assign errCount1  = cntQ[1];

endmodule

// File: rtl/qt_seq.sv
module qt_seq
  import qt_pkg::*;
#(
  parameter int ROWS_PER_HALF = 128,
  parameter int COLS          = 256,
  localparam int RB = $clog2(ROWS_PER_HALF),
  localparam int CB = $clog2(COLS),
  localparam int CW = $clog2(ROWS_PER_HALF + 1),
  localparam int AW = 1 + RB + CB
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] budgetHalf0,
  input  logic [CW-1:0] budgetHalf1,
  output logic [AW-1:0] memAddr,
  output logic          memWdata,
  output logic          memWe,
  input  logic          memRdata,
  output logic          busy,
  output logic          done,
  output logic          passed,
  output logic          unrepairable,
  output logic          contactReq,
  output logic [CW-1:0] errCount0,
  output logic [CW-1:0] errCount1
);

  seqStrobe_t strobe;
  logic       overBudget;
  logic       lastStep;
  logic       inHalf1;

  qt_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .overBudget   (overBudget),
    .lastStep     (lastStep),
    .inHalf1      (inHalf1),
    .strobe       (strobe),
    .memWe        (memWe),
    .busy         (busy),
    .done         (done),
    .unrepairable (unrepairable)
  );

  qt_datapath #(
    .ROWS_PER_HALF (ROWS_PER_HALF),
    .COLS          (COLS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .memRdata    (memRdata),
    .budgetHalf0 (budgetHalf0),
    .budgetHalf1 (budgetHalf1),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .errCount0   (errCount0),
    .errCount1   (errCount1),
    .overBudget  (overBudget),
    .lastStep    (lastStep),
    .inHalf1     (inHalf1)
  );

  assign passed     = done && !unrepairable;
  assign contactReq = unrepairable;

endmodule

// File: rtl/qt_seq_chk.sv
module qt_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          unrepairable,
  input logic [CW-1:0] errCount0,
  input logic [CW-1:0] errCount1
);

  // R3
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (!memWe && $stable(memAddr)));

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6
  count_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (errCount0 >= $past(errCount0) && errCount1 >= $past(errCount1)));

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> ($stable(errCount0) && $stable(errCount1)));

  // R8
  early_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unrepairable && !start) |=> (!memWe && !busy));

endmodule

bind qt_seq qt_seq_chk #(.AW(AW), .CW(CW)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .memWe        (memWe),
  .memAddr      (memAddr),
  .unrepairable (unrepairable),
  .errCount0    (errCount0),
  .errCount1    (errCount1)
);

// File: tb/sim_qt_seq.sv
module sim_qt_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int COLS = 12;
  localparam int RB = 4;
  localparam int CB = 4;
  localparam int CW = 5;
  localparam int AW = 1 + RB + CB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] b0 = 5'd8;
  logic [CW-1:0] b1 = 5'd8;
  logic [AW-1:0] memAddr;
  logic          memWdata, memWe, memRdata;
  logic          busy, done, passed, unrepairable, contactReq;
  logic [CW-1:0] errCount0, errCount1;

  int checks = 0;
  int fails  = 0;
  int busyCyc = 0;

  bit mem [0:(1<<AW)-1];
  int stuck [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  qt_seq #(.ROWS_PER_HALF(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .budgetHalf0(b0), .budgetHalf1(b1),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .busy(busy), .done(done), .passed(passed), .unrepairable(unrepairable),
    .contactReq(contactReq), .errCount0(errCount0), .errCount1(errCount1)
  );

  // memory with injectable stuck cells
  initial memRdata = 1'b0;
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (stuck.exists(int'(memAddr))) memRdata <= stuck[int'(memAddr)][0];
    else memRdata <= mem[memAddr];
  end

  // behavioural reference: 0 idle,1 write,2 read,3 check,4 done
  int mSt = 0, mHalf = 0, mRow = 0, mCol = 0;
  int mCnt [2] = '{0, 0};
  bit mFail = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mHalf = 0; mRow = 0; mCol = 0; mCnt[0] = 0; mCnt[1] = 0; mFail = 0;
    end else begin
      case (mSt)
        0, 4: if (start) begin
          mSt = 1; mHalf = 0; mRow = 0; mCol = 0; mCnt[0] = 0; mCnt[1] = 0; mFail = 0;
        end
        1: mSt = 2;
        2: mSt = 3;
        default: begin
          if (int'(memRdata) != mRow % 2) mCnt[mHalf]++;
          if (mCnt[mHalf] > int'(mHalf ? b1 : b0)) begin
            mFail = 1; mSt = 4;
          end else if (mRow == ROWS - 1) begin
            if (mHalf == 1) mSt = 4;
            else begin mHalf = 1; mRow = 0; mCol = 0; mSt = 1; end
          end else begin
            mRow++; mCol = (mCol + 1) % COLS; mSt = 1;
          end
        end
      endcase
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the reference every cycle
  always @(negedge clk) begin
    if (busy) busyCyc++;
    if (rstN) begin
      cmp("R2", "busy", int'(busy), int'(mSt >= 1 && mSt <= 3));
      cmp("R2", "done", int'(done), int'(mSt == 4));
      cmp("R3", "memWe", int'(memWe), int'(mSt == 1));
      if (mSt >= 1 && mSt <= 3)
        cmp("R5", "memAddr", int'(memAddr), mHalf * (1 << (RB + CB)) + mRow * (1 << CB) + mCol);
      if (mSt == 1) cmp("R4", "memWdata", int'(memWdata), mRow % 2);
      cmp("R6", "errCount0", int'(errCount0), mCnt[0]);
      cmp("R6", "errCount1", int'(errCount1), mCnt[1]);
      cmp("R8", "unrepairable", int'(unrepairable), int'(mSt == 4 && mFail));
      cmp("R8", "contactReq", int'(contactReq), int'(mSt == 4 && mFail));
      cmp("R7", "passed", int'(passed), int'(mSt == 4 && !mFail));
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  function automatic int adr(input int h, input int r, input int c);
    return h * 256 + r * 16 + c;
  endfunction

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic runWalk();
    busyCyc = 0;
    pulseStart();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "busy", int'(busy), 0);
    cmp("R1", "done", int'(done), 0);
    cmp("R1", "memWe", int'(memWe), 0);
    cmp("R1", "counts", int'(errCount0) + int'(errCount1), 0);
    cmp("R1", "flags", int'(passed) + int'(unrepairable) + int'(contactReq), 0);
    rstN = 1'b1;
    @(negedge clk);

    // clean memory
    runWalk();
    cmp("R7", "passed clean", int'(passed), 1);
    cmp("R5", "busy cycles clean", busyCyc, 2 * ROWS * 3);

    // faults: both polarities, one past the column wrap, one off the path
    stuck[adr(0, 2, 2)]  = 1;
    stuck[adr(0, 5, 5)]  = 0;
    stuck[adr(0, 13, 1)] = 0;
    stuck[adr(0, 0, 3)]  = 1;
    stuck[adr(1, 0, 0)]  = 1;
    stuck[adr(1, 7, 7)]  = 0;
    runWalk();
    cmp("R6", "count half0", int'(errCount0), 3);
    cmp("R6", "count half1", int'(errCount1), 2);
    cmp("R4", "passed with faults", int'(passed), 1);

    // budget equal to count
    b1 = 5'd2;
    runWalk();
    cmp("R7", "passed at budget", int'(passed), 1);

    // budget one below count: stop on the exceeding compare
    b1 = 5'd1;
    runWalk();
    cmp("R8", "unrepairable", int'(unrepairable), 1);
    cmp("R8", "contactReq", int'(contactReq), 1);
    cmp("R8", "count half1", int'(errCount1), 2);
    cmp("R8", "busy cycles", busyCyc, (ROWS + 8) * 3);

    // zero budget in half 0: half 1 never touched
    b0 = 5'd0; b1 = 5'd8;
    runWalk();
    cmp("R8", "count half0", int'(errCount0), 1);
    cmp("R8", "count half1 untouched", int'(errCount1), 0);
    cmp("R8", "busy cycles early", busyCyc, 9);

    // start while busy is ignored
    b0 = 5'd8;
    busyCyc = 0;
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    while (!done) @(negedge clk);
    cmp("R9", "busy cycles", busyCyc, 2 * ROWS * 3);
    cmp("R9", "count half0", int'(errCount0), 3);

    // results hold, then a new start clears
    repeat (5) @(negedge clk);
    cmp("R10", "count half0 held", int'(errCount0), 3);
    cmp("R10", "count half1 held", int'(errCount1), 2);
    cmp("R10", "passed held", int'(passed), 1);
    pulseStart();
    cmp("R2", "counts cleared", int'(errCount0) + int'(errCount1), 0);
    cmp("R2", "busy after start", int'(busy), 1);
    while (!done) @(negedge clk);
    summary();
  end

endmodule